// File: doc/BRIEF.md
# Bus Target Claim Controller

This block is the control core of a target on a shared parallel bus with active-low framing. Each clock it samples the initiator's cycle-framing line (`frame_n`), the initiator-ready line (`irdy_n`) and a `hit` flag from an address decoder that may need several clocks to resolve. From these it decides whether to claim a transaction and serve its data phases, or to follow a cycle that belongs to another agent until the bus goes quiet.

A claimed cycle is announced by driving the device-select and target-ready lines low. A data word moves on every clock where initiator-ready and target-ready are both low. The controller must claim a single-phase cycle even when framing has already been released by the time the slow decoder reports a hit, because initiator-ready is still low. After a claimed cycle ends it spends one turnaround clock before it can see a new address phase. If no hit arrives within a bounded number of clocks after the address phase, it stops waiting for one and stays silent until the bus is idle.

Top module: `bus_target_fsm`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is IDLE (code 0) with `devsel_n` and `trdy_n` high and `xfer` low. State codes on `state_o` are IDLE=0, BUSY=1, DATA=2, TURN=3.
- R2: In IDLE, a low `frame_n` moves to DATA if `hit` is high and to BUSY if `hit` is low. A high `frame_n` keeps IDLE.
- R3: In BUSY, the state holds while at least one of `frame_n` and `irdy_n` is low and no hit is accepted.
- R4: In BUSY, a high `hit` while `frame_n` or `irdy_n` is low moves to DATA, provided fewer than DECODE_LIMIT (default 3) BUSY clocks have passed since entering BUSY. This includes the single-phase case with `frame_n` high and `irdy_n` low.
- R5: BUSY returns to IDLE only on a clock where `frame_n` and `irdy_n` are both high.
- R6: Once DECODE_LIMIT BUSY clocks have passed without a hit, `hit` is ignored. The state stays BUSY with `devsel_n` high until both lines are high.
- R7: `devsel_n` and `trdy_n` are low in DATA and high in every other state.
- R8: `xfer` is high exactly on clocks where the state is DATA and `irdy_n` is low.
- R9: DATA moves to TURN after a clock where `xfer` is high and `frame_n` is high. Otherwise it stays in DATA.
- R10: TURN lasts one clock. It then goes to BUSY if `frame_n` is low and to IDLE otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Cycle framing from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| hit | input | 1 | Address decoder match, active high |
| devsel_n | output | 1 | Device select, active low, registered |
| trdy_n | output | 1 | Target ready, active low, registered |
| state_o | output | 2 | Current state code |
| xfer | output | 1 | Data word moves this clock |

## Verification
`state_o`, `devsel_n` and `trdy_n` take the value selected by the inputs sampled at a rising edge, so they are due one clock after the stimulus. `xfer` is combinational from the current state and `irdy_n`, so it is due in the same clock. The bench drives inputs on the falling edge and checks `xfer` shortly afterwards. It checks the registered outputs one time step after the next rising edge, against a bench model that follows the same one-clock rule and counts BUSY clocks to decide when a hit is still accepted.

// File: rtl/bus_tgt_pkg.sv
package bus_tgt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DATA = 2'd2,
      ST_TURN = 2'd3
   } tgt_state_e;
endpackage

// File: rtl/bus_tgt_decode_timer.sv
module bus_tgt_decode_timer #(
   parameter int LIMIT = 3,
   localparam int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_busy,
   output logic expired
);
   generate
      if (LIMIT == 1) begin : g_flop
         logic seen;
         always_ff @(posedge clk) begin
            if (!rst_n || !in_busy) seen <= 1'b0;
            else                    seen <= 1'b1;
         end
         assign expired = seen;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !in_busy)       cnt <= '0;
            else if (cnt != CNT_W'(LIMIT)) cnt <= cnt + 1'b1;
         end
         assign expired = (cnt == CNT_W'(LIMIT));
      end
   endgenerate
endmodule

// File: rtl/bus_tgt_next_state.sv
module bus_tgt_next_state
   import bus_tgt_pkg::*;
(
   input  tgt_state_e cur,
   input  logic       frame_n,
   input  logic       irdy_n,
   input  logic       hit,
   input  logic       expired,
   output tgt_state_e nxt
);
   logic active;
   assign active = !frame_n || !irdy_n;

   always_comb begin
      nxt = cur;
      unique case (cur)
         ST_IDLE: if (!frame_n) nxt = hit ? ST_DATA : ST_BUSY;
         ST_BUSY: begin
            if (active && hit && !expired) nxt = ST_DATA;
            else if (!active)              nxt = ST_IDLE;
         end
         ST_DATA: if (!irdy_n && frame_n) nxt = ST_TURN;
         ST_TURN: nxt = !frame_n ? ST_BUSY : ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/bus_tgt_out_drive.sv
module bus_tgt_out_drive
   import bus_tgt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  tgt_state_e cur,
   input  tgt_state_e nxt,
   input  logic       irdy_n,
   output logic       devsel_n,
   output logic       trdy_n,
   output logic       xfer
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         devsel_n <= 1'b1;
         trdy_n   <= 1'b1;
      end else begin
         devsel_n <= (nxt != ST_DATA);
         trdy_n   <= (nxt != ST_DATA);
      end
   end

   assign xfer = (cur == ST_DATA) && !irdy_n;
endmodule

// File: rtl/bus_target_fsm.sv
module bus_target_fsm
   import bus_tgt_pkg::*;
#(
   parameter int DECODE_LIMIT = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic       irdy_n,
   input  logic       hit,
   output logic       devsel_n,
   output logic       trdy_n,
   output logic [1:0] state_o,
   output logic       xfer
);
   generate
      if (DECODE_LIMIT < 1) begin : g_bad_limit
         $error("DECODE_LIMIT must be at least 1");
      end
   endgenerate

   tgt_state_e cur, nxt;
   logic       expired;

   bus_tgt_decode_timer #(.LIMIT(DECODE_LIMIT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_busy (cur == ST_BUSY),
      .expired (expired)
   );

   bus_tgt_next_state u_next (
      .cur     (cur),
      .frame_n (frame_n),
      .irdy_n  (irdy_n),
      .hit     (hit),
      .expired (expired),
      .nxt     (nxt)
   );

   bus_tgt_out_drive u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur      (cur),
      .nxt      (nxt),
      .irdy_n   (irdy_n),
      .devsel_n (devsel_n),
      .trdy_n   (trdy_n),
      .xfer     (xfer)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) cur <= ST_IDLE;
      else        cur <= nxt;
   end

   assign state_o = cur;
endmodule

// File: rtl/bus_target_fsm_checker.sv
module bus_target_fsm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_n,
   input logic       irdy_n,
   input logic       hit,
   input logic       devsel_n,
   input logic       trdy_n,
   input logic [1:0] state_o,
   input logic       xfer
);
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (state_o == 2'd0) && devsel_n && trdy_n);

   a_r5_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1) && frame_n && irdy_n |=> (state_o == 2'd0));

   a_r7_select_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
      (devsel_n == (state_o != 2'd2)) && (trdy_n == devsel_n));

   a_r8_xfer_needs_both_ready: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |-> !irdy_n && !trdy_n);

   a_r9_last_word_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2) && !irdy_n && frame_n |=> (state_o == 2'd3));

   a_r10_turn_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3) |=> (state_o == 2'd0) || (state_o == 2'd1));

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0) && frame_n |=> (state_o == 2'd0));
endmodule

bind bus_target_fsm bus_target_fsm_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .frame_n  (frame_n),
   .irdy_n   (irdy_n),
   .hit      (hit),
   .devsel_n (devsel_n),
   .trdy_n   (trdy_n),
   .state_o  (state_o),
   .xfer     (xfer)
);

// File: tb/bus_target_fsm_bench.sv
`timescale 1ns/1ps
module bus_target_fsm_bench;
   localparam int LIM = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_n = 1'b1, irdy_n = 1'b1, hit = 1'b0;
   logic       devsel_n, trdy_n, xfer;
   logic [1:0] state_o;

   int checks = 0, failures = 0;
   int ms = 0, mcnt = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bus_target_fsm #(.DECODE_LIMIT(LIM)) u_bus_target_fsm (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .hit(hit),
      .devsel_n(devsel_n), .trdy_n(trdy_n), .state_o(state_o), .xfer(xfer)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_next(int s, int cnt, bit f, bit i, bit h);
      bit act = !f || !i;
      case (s)
         0: return !f ? (h ? 2 : 1) : 0;
         1: if (act && h && cnt < LIM) return 2;
            else if (!act) return 0;
            else return 1;
         2: return (!i && f) ? 3 : 2;
         default: return !f ? 1 : 0;
      endcase
   endfunction

   function automatic string tag(int s, int cnt, bit f, bit i, bit h);
      case (s)
         0: return "R2";
         1: if ((!f || !i) && h && cnt < LIM) return "R4";
            else if ((!f || !i) && h) return "R6";
            else if (!f || !i) return "R3";
            else return "R5";
         2: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic step(bit f, bit i, bit h);
      int ns;
      string t;
      @(negedge clk);
      frame_n = f; irdy_n = i; hit = h;
      #1;
      check("R8", int'(xfer), int'(ms == 2 && !i));
      ns = exp_next(ms, mcnt, f, i, h);
      t  = tag(ms, mcnt, f, i, h);
      @(posedge clk);
      #1;
      if (ms == 1 && ns == 1) mcnt = (mcnt < LIM) ? mcnt + 1 : LIM;
      else mcnt = 0;
      ms = ns;
      check(t, int'(state_o), ms);
      check("R7", int'(devsel_n), int'(ms != 2));
      check("R7", int'(trdy_n), int'(ms != 2));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; hit = 1'b0;
      @(posedge clk);
      #1;
      ms = 0; mcnt = 0;
      check("R1", int'(state_o), 0);
      check("R1", int'(devsel_n), 1);
      check("R1", int'(trdy_n), 1);
      check("R1", int'(xfer), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (2) @(posedge clk);
      do_reset();
      // single-phase cycle with slow decode: claim with frame released
      step(0, 1, 0); step(1, 0, 0); step(1, 0, 1); step(1, 0, 0); step(1, 1, 0);
      // foreign cycle: decode gives up, later hit ignored (R6), release (R5)
      step(0, 1, 0); step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
      step(0, 0, 1); step(1, 0, 1); step(1, 1, 0);
      // fast hit burst with wait state, then back-to-back cycle via TURN (R10)
      step(0, 1, 1); step(0, 1, 0); step(0, 0, 0); step(1, 0, 0);
      step(0, 1, 0); step(0, 1, 1); step(1, 1, 0); step(1, 0, 0); step(1, 1, 0);
      // hit on the last accepted BUSY clock (R4 boundary)
      step(0, 1, 0); step(0, 1, 0); step(0, 1, 0); step(0, 1, 1); step(1, 0, 0); step(1, 1, 0);
      // reset in the middle of a claimed cycle
      step(0, 1, 1);
      do_reset();
      // constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         bit f = ($urandom % 100) < 55 ? 1'b0 : 1'b1;
         bit i = ($urandom % 100) < 60 ? 1'b0 : 1'b1;
         bit h = ($urandom % 100) < 30;
         step(f, i, h);
         if (n % 700 == 699) do_reset();
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule